// File: doc/BRIEF.md
# Protected DMA Memory Range Checker

The block holds one lower bound and one upper bound that together describe a protected window in low physical memory. Every DMA address presented to it is compared against this window. While protection is on, an address that falls inside the window raises `blocked_o` in the same cycle.

Software programs both bounds through a small register port. Only the upper bits of each bound, at and above bit GRAN_MSB+1, are stored. The lower bits always read back as zero. For matching, the lower bits of the upper bound are taken as all ones and those of the lower bound as all zeros, so the window always covers whole aligned granules. The bounds can be frozen in three ways: by a lock pulse, by a strap saying the region is not supported, or by protection being enabled.

Top module: `pmr_guard`

## Requirements
- R1: After reset, both bounds read back 0x00000000 and `blocked_o` is low while `prot_en_i` is low.
- R2: Bits 20:0 of `reg_rdata_o` always read zero. Writing 0xFFFFFFFF to an unlocked bound reads back 0xFFE00000, so the lowest bit reading one is bit 21.
- R3: A write to a bound takes effect only when `cap_low_i` is 1, the bound is unlocked and `prot_en_i` is 0. The new value is visible on `reg_rdata_o` in the cycle after the write. `reg_sel_i` selects the bound: 0 for the lower bound, 1 for the upper bound.
- R4: A `lock_i` pulse makes both bounds ignore writes from the next cycle on. An `unlock_i` pulse makes them writable again from the next cycle on. If both pulses arrive in the same cycle, the lock wins.
- R5: While `cap_low_i` is 0, writes have no effect and `blocked_o` stays low.
- R6: While `prot_en_i` is 1, writes have no effect, so the bounds used for matching do not change.
- R7: When `prot_en_i` and `cap_low_i` are 1, `blocked_o` is high exactly when {base[31:21],21'h0} ≤ `dma_addr_i` ≤ {limit[31:21],21'h1FFFFF}, using unsigned 32-bit comparison, with no register delay.
- R8: When the two bounds hold equal upper bits, the window covers exactly 2 MiB (2^21 bytes) starting at the lower bound.
- R9: When the upper bound's stored bits are below the lower bound's, no address is blocked.
- R10: While `prot_en_i` is 0, `blocked_o` is low for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_low_i | input | 1 | Strap: 1 means the protected low region is supported |
| prot_en_i | input | 1 | Protection enable |
| lock_i | input | 1 | Single-cycle lock command |
| unlock_i | input | 1 | Single-cycle unlock command |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Bound select: 0 lower, 1 upper |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected bound |
| dma_addr_i | input | 32 | DMA request address |
| blocked_o | output | 1 | High when the request falls in the active window |

## Verification
The assertions assume that `lock_i` and `unlock_i` are pulses, sampled on the clock. They also assume that `cap_low_i` and `prot_en_i` are levels that software changes only between accesses, not glitches inside a cycle. The bench drives every input at the falling edge, so each value holds across a whole rising edge. Lock and unlock are given low probabilities, so most runs spend long stretches unlocked, and the same-cycle collision of the two pulses is also driven in a directed case. DMA addresses are drawn around the current granule edges, so that inclusive bound matching is exercised as well as wide random values.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } pmr_sel_e;
endpackage

// File: rtl/pmr_lock_ctrl.sv
module pmr_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic unlock_i,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       locked_o <= 1'b0;
    else if (lock_i)   locked_o <= 1'b1;  // lock wins a collision
    else if (unlock_i) locked_o <= 1'b0;
  end
endmodule

// File: rtl/pmr_bound_reg.sv
module pmr_bound_reg #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_MSB  = 20,
  parameter bit          FILL_ONES = 1'b0,
  localparam int unsigned HI_W     = ADDR_W - GRAN_MSB - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [HI_W-1:0]   wdata_i,
  output logic [HI_W-1:0]   hi_o,
  output logic [ADDR_W-1:0] rd_o,
  output logic [ADDR_W-1:0] eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hi_o <= '0;
    else if (we_i) hi_o <= wdata_i;
  end

  assign rd_o = {hi_o, {(GRAN_MSB+1){1'b0}}};

  generate
    if (FILL_ONES) begin : g_fill_ones
      assign eff_o = {hi_o, {(GRAN_MSB+1){1'b1}}};
    end else begin : g_fill_zeros
      assign eff_o = {hi_o, {(GRAN_MSB+1){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/pmr_window_cmp.sv
module pmr_window_cmp #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_MSB = 20,
  localparam int unsigned HI_W    = ADDR_W - GRAN_MSB - 1
) (
  input  logic              active_i,
  input  logic [HI_W-1:0]   base_hi_i,
  input  logic [HI_W-1:0]   lim_hi_i,
  input  logic [ADDR_W-1:0] base_eff_i,
  input  logic [ADDR_W-1:0] lim_eff_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic win_valid;
  logic above_base;
  logic below_lim;

  assign win_valid  = (lim_hi_i >= base_hi_i);
  assign above_base = (addr_i >= base_eff_i);
  assign below_lim  = (addr_i <= lim_eff_i);
  assign hit_o      = active_i & win_valid & above_base & below_lim;
endmodule

// File: rtl/pmr_guard.sv
module pmr_guard #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_MSB = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_low_i,
  input  logic              prot_en_i,
  input  logic              lock_i,
  input  logic              unlock_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] dma_addr_i,
  output logic              blocked_o
);
  import pmr_pkg::*;
  localparam int unsigned HI_W = ADDR_W - GRAN_MSB - 1;

  pmr_sel_e          sel;
  logic              locked_q;
  logic              wr_ok;
  logic [HI_W-1:0]   base_hi, lim_hi;
  logic [ADDR_W-1:0] base_rd, lim_rd, base_eff, lim_eff;
  logic              unused_wlow;

  assign sel         = pmr_sel_e'(reg_sel_i);
  assign unused_wlow = ^reg_wdata_i[GRAN_MSB:0];

  pmr_lock_ctrl i_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_i),
    .unlock_i (unlock_i),
    .locked_o (locked_q)
  );

  assign wr_ok = reg_we_i & cap_low_i & ~locked_q & ~prot_en_i;

  pmr_bound_reg #(.ADDR_W(ADDR_W), .GRAN_MSB(GRAN_MSB), .FILL_ONES(1'b0)) i_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok && sel == SEL_BASE),
    .wdata_i (reg_wdata_i[ADDR_W-1:GRAN_MSB+1]),
    .hi_o    (base_hi),
    .rd_o    (base_rd),
    .eff_o   (base_eff)
  );

  pmr_bound_reg #(.ADDR_W(ADDR_W), .GRAN_MSB(GRAN_MSB), .FILL_ONES(1'b1)) i_limit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok && sel == SEL_LIMIT),
    .wdata_i (reg_wdata_i[ADDR_W-1:GRAN_MSB+1]),
    .hi_o    (lim_hi),
    .rd_o    (lim_rd),
    .eff_o   (lim_eff)
  );

  assign reg_rdata_o = (sel == SEL_LIMIT) ? lim_rd : base_rd;

  pmr_window_cmp #(.ADDR_W(ADDR_W), .GRAN_MSB(GRAN_MSB)) i_cmp (
    .active_i   (prot_en_i & cap_low_i),
    .base_hi_i  (base_hi),
    .lim_hi_i   (lim_hi),
    .base_eff_i (base_eff),
    .lim_eff_i  (lim_eff),
    .addr_i     (dma_addr_i),
    .hit_o      (blocked_o)
  );
endmodule

// File: rtl/pmr_guard_chk.sv
module pmr_guard_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_MSB = 20,
  localparam int unsigned HI_W    = ADDR_W - GRAN_MSB - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_low_i,
  input logic              prot_en_i,
  input logic              lock_i,
  input logic              locked_q,
  input logic [HI_W-1:0]   base_hi,
  input logic [HI_W-1:0]   lim_hi,
  input logic [ADDR_W-1:0] dma_addr_i,
  input logic              blocked_o
);
  AST_LOCK_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> locked_q);  // R4
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> ($stable(base_hi) && $stable(lim_hi)));  // R4
  AST_NOCAP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_low_i |=> ($stable(base_hi) && $stable(lim_hi)));  // R5
  AST_NOCAP_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_low_i |-> !blocked_o);  // R5
  AST_EN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_en_i |=> ($stable(base_hi) && $stable(lim_hi)));  // R6
  AST_HIT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |-> (dma_addr_i[ADDR_W-1:GRAN_MSB+1] >= base_hi &&
                   dma_addr_i[ADDR_W-1:GRAN_MSB+1] <= lim_hi));  // R7
  AST_INVERTED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_hi < base_hi) |-> !blocked_o);  // R9
  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_i |-> !blocked_o);  // R10
endmodule

bind pmr_guard pmr_guard_chk #(.ADDR_W(ADDR_W), .GRAN_MSB(GRAN_MSB)) i_pmr_guard_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_low_i  (cap_low_i),
  .prot_en_i  (prot_en_i),
  .lock_i     (lock_i),
  .locked_q   (locked_q),
  .base_hi    (base_hi),
  .lim_hi     (lim_hi),
  .dma_addr_i (dma_addr_i),
  .blocked_o  (blocked_o)
);

// File: tb/test_pmr_guard.sv
module test_pmr_guard;
  localparam int unsigned AW = 32;
  localparam int unsigned GM = 20;
  localparam logic [AW-1:0] LOW_MASK = (32'h1 << (GM+1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap, en, lk, ul, we, sel;
  logic [AW-1:0] wd, addr, rd;
  logic blk;

  int n_chk = 0;
  int n_bad = 0;

  logic [AW-1:0] m_base = '0;
  logic [AW-1:0] m_lim  = '0;
  logic          m_locked = 1'b0;

  always #10 clk = ~clk;

  pmr_guard #(.ADDR_W(AW), .GRAN_MSB(GM)) i_pmr_guard (
    .clk_i(clk), .rst_ni(rst_n), .cap_low_i(cap), .prot_en_i(en),
    .lock_i(lk), .unlock_i(ul), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .dma_addr_i(addr), .blocked_o(blk)
  );

  function automatic logic exp_blk(logic [AW-1:0] b, logic [AW-1:0] l,
                                   logic [AW-1:0] a, logic e, logic c);
    logic [AW-1:0] lo, hi;
    lo = b & ~LOW_MASK;
    hi = l | LOW_MASK;
    return e && c && (l >= b) && (a >= lo) && (a <= hi);
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check outputs, then advance the model.
  task automatic cyc(string tag, logic w, logic s, logic [AW-1:0] d, logic l, logic u,
                     logic e, logic c, logic [AW-1:0] a);
    @(negedge clk);
    we = w; sel = s; wd = d; lk = l; ul = u; en = e; cap = c; addr = a;
    #2;
    chk({tag, " rdata"}, rd, s ? m_lim : m_base);
    chk({tag, " blocked"}, {31'b0, blk}, {31'b0, exp_blk(m_base, m_lim, a, e, c)});
    if (w && c && !m_locked && !e) begin
      if (s) m_lim = d & ~LOW_MASK;
      else   m_base = d & ~LOW_MASK;
    end
    if (l) m_locked = 1'b1;
    else if (u) m_locked = 1'b0;
  endtask

  task automatic idle(string tag, logic s, logic e, logic [AW-1:0] a);
    cyc(tag, 1'b0, s, '0, 1'b0, 1'b0, e, 1'b1, a);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    cap = 1'b1; en = 1'b0; lk = 1'b0; ul = 1'b0; we = 1'b0; sel = 1'b0; wd = '0; addr = '0;
    // R1: reset state
    #3;
    chk("R1 base", rd, 32'h0);
    sel = 1'b1; #1;
    chk("R1 limit", rd, 32'h0);
    chk("R1 blocked", {31'b0, blk}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: all-ones write discovers granule
    cyc("R2", 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    idle("R2", 1'b1, 1'b0, '0);
    chk("R2 readback", rd, 32'hFFE0_0000);

    // R8: equal bounds give a 2 MiB window
    cyc("R3", 1'b1, 1'b0, 32'h0041_2345, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    cyc("R3", 1'b1, 1'b1, 32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    idle("R3", 1'b0, 1'b0, '0);
    chk("R3 base", rd, 32'h0040_0000);
    idle("R8 below", 1'b1, 1'b1, 32'h003F_FFFF);
    idle("R8 first", 1'b1, 1'b1, 32'h0040_0000);
    idle("R8 last",  1'b1, 1'b1, 32'h005F_FFFF);
    idle("R8 past",  1'b1, 1'b1, 32'h0060_0000);
    chk("R8 last direct", {31'b0, exp_blk(m_base, m_lim, 32'h005F_FFFF, 1'b1, 1'b1)}, 32'h1);

    // R10: disabled blocks nothing
    idle("R10", 1'b1, 1'b0, 32'h0050_0000);

    // R6: writes ignored while enabled
    cyc("R6", 1'b1, 1'b1, 32'h0100_0000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0050_0000);
    idle("R6", 1'b1, 1'b1, 32'h0050_0000);
    chk("R6 limit kept", rd, 32'h0040_0000);

    // R9: inverted bounds
    cyc("R9", 1'b1, 1'b1, 32'h0020_0000, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    idle("R9", 1'b1, 1'b1, 32'h0030_0000);
    idle("R9", 1'b1, 1'b1, 32'h0040_0000);
    chk("R9 no hit", {31'b0, blk}, 32'h0);

    // R4: lock wins a collision, unlock restores
    cyc("R4", 1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0, 1'b1, '0);
    cyc("R4", 1'b1, 1'b1, 32'h0080_0000, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    idle("R4", 1'b1, 1'b0, '0);
    chk("R4 locked limit", rd, 32'h0020_0000);
    cyc("R4", 1'b0, 1'b1, '0, 1'b0, 1'b1, 1'b0, 1'b1, '0);
    cyc("R4", 1'b1, 1'b1, 32'h0080_0000, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    idle("R4", 1'b1, 1'b0, '0);
    chk("R4 unlocked limit", rd, 32'h0080_0000);

    // R5: no capability
    cyc("R5", 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    cyc("R5", 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0050_0000);
    chk("R5 base kept", rd, 32'h0040_0000);

    // R7 and R3: random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a, d;
      int unsigned pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = m_base - 1;
        1: a = m_base;
        2: a = m_lim | LOW_MASK;
        3: a = (m_lim | LOW_MASK) + 1;
        default: a = $urandom();
      endcase
      d = ($urandom_range(0, 3) == 0) ? $urandom() : (32'($urandom_range(0, 15)) << (GM+1));
      cyc("R7", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, d,
          $urandom_range(0, 19) == 0, $urandom_range(0, 11) == 0,
          $urandom_range(0, 3) != 0, $urandom_range(0, 9) != 0, a);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule